// File: doc/BRIEF.md
# Basic Timer Time-Base Unit

This block is a free-running up-counter with a programmable clock divider in front of it. It is used to produce a periodic tick for software and a trigger pulse for a downstream converter. Software programs a divide ratio and a terminal count through a small register bus. The counter then runs from zero up to the terminal count, wraps, and raises an update event on each wrap.

The divide ratio and the terminal count each have a preload copy and an active copy. An update event moves the preload copies into the active copies, so a new setting starts on a clean period boundary. An update event comes from a wrap or from a software strobe. Software can suppress update events entirely, or it can keep software strobes from raising the flag. A one-shot mode stops the counter at its first update.

The outputs are a level interrupt, a one-cycle DMA request and a trigger line. The trigger line can carry the software strobe, the internal run signal or the update event.

Top module: `basic_tmr`

## Requirements
- R1: With an active prescale value P and an active nonzero limit L, the counter steps 0, 1, ..., L, then wraps to 0. The wrap is an overflow event, and overflow events repeat every (L+1)*(P+1) clocks.
- R2: The prescale register (address 6) is a preload. A new value has no effect until the next update event, after which a counter step occurs every P+1 clocks.
- R3: When control bit 4 (limit preload) is 1, a write to the limit register (address 7) changes only the preload, and the active limit follows at the next update event. When it is 0, the write changes the active limit at once. Reads of address 7 return the preload.
- R4: Writing 1 to bit 0 of the event register (address 4) is a software update strobe. The strobe clears the counter and the prescale counter at that edge. It does not hold, and address 4 always reads 0.
- R5: While control bit 1 (update inhibit) is 1, no update event occurs and the active prescale and limit values are kept. The counter still wraps, and a software strobe still clears the counter.
- R6: While control bit 2 (overflow-only flag) is 1, a software strobe does not set the flag, but an overflow still sets it. While the bit is 0, both sources set the flag.
- R7: While control bit 3 (one-shot) is 1, an update event clears control bit 0 (run), and the counter stays at 0 afterwards.
- R8: The internal run signal follows control bit 0 one clock later. The first counter step after enabling therefore falls on the second rising edge after the control write.
- R9: The trigger select (address 1, bits 2:0) chooses the trigger output: 000 gives the software strobe, 001 gives the internal run signal, 010 gives the update event, and 011 to 111 drive the output low. Each of the first three appears as a one-clock level in the cycle after its edge.
- R10: While the active limit is 0, the counter does not step and no overflow occurs.
- R11: Status bit 0 (address 3) is the flag. Hardware sets it. A write of 0 clears it unless a flag-setting update happens in the same cycle, and a write of 1 has no effect. irq_o is the flag ANDed with enable bit 0 (address 2).
- R12: When enable bit 1 (address 2) is 1, each flag-setting update produces a one-clock pulse on dma_req_o in the following cycle. When the bit is 0, dma_req_o stays low.
- R13: After reset every register reads 0 and all outputs are low. Control occupies address 0 with run in bit 0. A bus write to the counter (address 5) loads it directly and overrides counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Interrupt level |
| dma_req_o | output | 1 | One-clock DMA request pulse |
| trig_o | output | 1 | Selected trigger output |

## Verification
The bench builds the block with CNT_W=8 and PSC_W=4. At these widths every period is only a few dozen clocks, so all prescale values from 0 to 3 can be swept against every limit from 1 to 5. Each of these twenty combinations is timed from the enable write to the first overflow and then across one full period, and the results are compared with the arithmetic product. The narrow widths also leave room to test the corner cases on short runs: a deferred prescale and limit change, update inhibit while wrapping, a zero limit, one-shot stop, and each trigger code.

// File: rtl/basic_tmr_pkg.sv
package basic_tmr_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL = 3'd0,
    ADR_TRIG = 3'd1,
    ADR_IEN  = 3'd2,
    ADR_STAT = 3'd3,
    ADR_EVT  = 3'd4,
    ADR_CNT  = 3'd5,
    ADR_PSC  = 3'd6,
    ADR_LIM  = 3'd7
  } reg_addr_e;

  // bit 0 is the LSB of the control word
  typedef struct packed {
    logic lim_pre;   // 4
    logic one_shot;  // 3
    logic ovf_only;  // 2
    logic inhibit;   // 1
    logic run;       // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] TRIG_SW_STROBE = 3'b000;
  localparam logic [2:0] TRIG_RUNNING   = 3'b001;
  localparam logic [2:0] TRIG_UPDATE    = 3'b010;

endpackage

// File: rtl/basic_tmr_cfg.sv
module basic_tmr_cfg
  import basic_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uev_i,
  input  logic              flag_set_i,
  input  logic              stop_i,
  output ctrl_t             ctrl_o,
  output logic [2:0]        trig_sel_o,
  output logic              irq_en_o,
  output logic              dma_en_o,
  output logic              flag_o,
  output logic [PSC_W-1:0]  psc_pre_o,
  output logic [PSC_W-1:0]  psc_act_o,
  output logic [CNT_W-1:0]  lim_pre_o,
  output logic [CNT_W-1:0]  lim_act_o,
  output logic              sw_upd_o,
  output logic              cnt_ld_o
);

  logic wr_ctrl, wr_trig, wr_ien, wr_stat, wr_psc, wr_lim;
  logic unused_wdata;

  assign wr_ctrl  = we_i && (addr_i == ADR_CTRL);
  assign wr_trig  = we_i && (addr_i == ADR_TRIG);
  assign wr_ien   = we_i && (addr_i == ADR_IEN);
  assign wr_stat  = we_i && (addr_i == ADR_STAT);
  assign wr_psc   = we_i && (addr_i == ADR_PSC);
  assign wr_lim   = we_i && (addr_i == ADR_LIM);
  assign sw_upd_o = we_i && (addr_i == ADR_EVT) && wdata_i[0];
  assign cnt_ld_o = we_i && (addr_i == ADR_CNT);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      trig_sel_o <= '0;
      irq_en_o   <= 1'b0;
      dma_en_o   <= 1'b0;
      flag_o     <= 1'b0;
      psc_pre_o  <= '0;
      psc_act_o  <= '0;
      lim_pre_o  <= '0;
      lim_act_o  <= '0;
    end else begin
      if (wr_ctrl)     ctrl_o     <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (stop_i) ctrl_o.run <= 1'b0;
      if (wr_trig) trig_sel_o <= wdata_i[2:0];
      if (wr_ien)  {dma_en_o, irq_en_o} <= wdata_i[1:0];
      // hardware set beats a same-cycle software clear
      if (flag_set_i)                flag_o <= 1'b1;
      else if (wr_stat && !wdata_i[0]) flag_o <= 1'b0;
      if (wr_psc) psc_pre_o <= wdata_i[PSC_W-1:0];
      if (uev_i)  psc_act_o <= psc_pre_o;
      if (wr_lim) lim_pre_o <= wdata_i[CNT_W-1:0];
      if (wr_lim && !ctrl_o.lim_pre) lim_act_o <= wdata_i[CNT_W-1:0];
      else if (uev_i)                lim_act_o <= lim_pre_o;
    end
  end

endmodule

// File: rtl/basic_tmr_psc.sv
module basic_tmr_psc #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] ratio_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] div_q;
  logic             last;

  assign last   = div_q >= ratio_i;
  assign tick_o = en_i && last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= last ? '0 : div_q + 1'b1;
  end

endmodule

// File: rtl/basic_tmr_cnt.sv
module basic_tmr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic live, at_top;

  assign live   = limit_i != '0;
  assign at_top = cnt_o == limit_i;
  assign ovf_o  = tick_i && live && at_top && !ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (ld_i)            cnt_o <= ld_val_i;
    else if (tick_i && live)  cnt_o <= at_top ? '0 : cnt_o + 1'b1;
  end

endmodule

// File: rtl/basic_tmr.sv
module basic_tmr
  import basic_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              trig_o
);

  ctrl_t            ctrl;
  logic [2:0]       trig_sel;
  logic             irq_en, dma_en, flag_q;
  logic [PSC_W-1:0] psc_pre, psc_act;
  logic [CNT_W-1:0] lim_pre, lim_act, cnt_q;
  logic             sw_upd, cnt_ld, tick, ovf;
  logic             uev, flag_set, stop;
  logic             run_q, sw_upd_q, uev_q, dma_q;

  assign uev      = !ctrl.inhibit && (ovf || sw_upd);
  assign flag_set = !ctrl.inhibit && (ovf || (sw_upd && !ctrl.ovf_only));
  assign stop     = uev && ctrl.one_shot;

  basic_tmr_cfg #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .uev_i(uev), .flag_set_i(flag_set), .stop_i(stop),
    .ctrl_o(ctrl), .trig_sel_o(trig_sel), .irq_en_o(irq_en), .dma_en_o(dma_en),
    .flag_o(flag_q), .psc_pre_o(psc_pre), .psc_act_o(psc_act),
    .lim_pre_o(lim_pre), .lim_act_o(lim_act),
    .sw_upd_o(sw_upd), .cnt_ld_o(cnt_ld)
  );

  basic_tmr_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni,
    .en_i(run_q), .clr_i(sw_upd), .ratio_i(psc_act), .tick_o(tick)
  );

  basic_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(tick), .clr_i(sw_upd), .ld_i(cnt_ld),
    .ld_val_i(bus_wdata_i[CNT_W-1:0]), .limit_i(lim_act),
    .cnt_o(cnt_q), .ovf_o(ovf)
  );

  // one-shot stop also drops the run stage so no extra step follows the wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      sw_upd_q <= 1'b0;
      uev_q    <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      run_q    <= ctrl.run && !stop;
      sw_upd_q <= sw_upd;
      uev_q    <= uev;
      dma_q    <= flag_set && dma_en;
    end
  end

  assign irq_o     = flag_q && irq_en;
  assign dma_req_o = dma_q;

  always_comb begin
    unique case (trig_sel)
      TRIG_SW_STROBE: trig_o = sw_upd_q;
      TRIG_RUNNING:   trig_o = run_q;
      TRIG_UPDATE:    trig_o = uev_q;
      default:        trig_o = 1'b0;
    endcase
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADR_CTRL: bus_rdata_o[CTRL_W-1:0] = ctrl;
      ADR_TRIG: bus_rdata_o[2:0]        = trig_sel;
      ADR_IEN:  bus_rdata_o[1:0]        = {dma_en, irq_en};
      ADR_STAT: bus_rdata_o[0]          = flag_q;
      ADR_EVT:  bus_rdata_o             = '0;
      ADR_CNT:  bus_rdata_o[CNT_W-1:0]  = cnt_q;
      ADR_PSC:  bus_rdata_o[PSC_W-1:0]  = psc_pre;
      ADR_LIM:  bus_rdata_o[CNT_W-1:0]  = lim_pre;
      default:  bus_rdata_o             = '0;
    endcase
  end

endmodule

// File: rtl/basic_tmr_chk.sv
module basic_tmr_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr,
  input logic             sw_upd,
  input logic             cnt_ld,
  input logic             ovf,
  input logic             uev,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] lim_act,
  input logic [PSC_W-1:0] psc_act,
  input logic             run,
  input logic             run_q,
  input logic             inhibit,
  input logic             ovf_only,
  input logic             one_shot,
  input logic             flag_q,
  input logic             dma_req_o
);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> cnt_q == '0); // R1

  AST_STROBE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_upd |=> cnt_q == '0); // R4

  AST_INHIBIT_KEEPS_PSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit |=> $stable(psc_act)); // R5

  AST_OVF_ONLY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_only && sw_upd && !flag_q) |=> !flag_q); // R6

  AST_ONE_SHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_shot && uev && !ctrl_wr) |=> !run); // R7

  AST_RUN_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> $past(run)); // R8

  AST_ZERO_LIMIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_act == '0 && !sw_upd && !cnt_ld) |=> $stable(cnt_q)); // R10

  AST_DMA_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> flag_q); // R12

endmodule

bind basic_tmr basic_tmr_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_wr   (bus_we_i && bus_addr_i == 3'd0),
  .sw_upd    (sw_upd),
  .cnt_ld    (cnt_ld),
  .ovf       (ovf),
  .uev       (uev),
  .cnt_q     (cnt_q),
  .lim_act   (lim_act),
  .psc_act   (psc_act),
  .run       (ctrl.run),
  .run_q     (run_q),
  .inhibit   (ctrl.inhibit),
  .ovf_only  (ctrl.ovf_only),
  .one_shot  (ctrl.one_shot),
  .flag_q    (flag_q),
  .dma_req_o (dma_req_o)
);

// File: tb/basic_tmr_test.sv
`timescale 1ns/1ps
module basic_tmr_test;

  localparam int CNT_W = 8;
  localparam int PSC_W = 4;
  localparam int DW    = 16;

  localparam logic [2:0] A_CTRL = 3'd0, A_TRIG = 3'd1, A_IEN = 3'd2, A_STAT = 3'd3,
                         A_EVT = 3'd4, A_CNT = 3'd5, A_PSC = 3'd6, A_LIM = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, dma, trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  basic_tmr #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .dma_req_o(dma),
    .trig_o(trig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!dma && n < 2000);
  endtask

  task automatic setup(input int psc, input int lim);
    wr(A_CTRL, 0);
    wr(A_PSC, psc);
    wr(A_LIM, lim);
    wr(A_EVT, 1);
    wr(A_STAT, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, n, mx, hits;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R13 reset reg %0d", a), d, 0);
    end
    chk("R13 reset irq", int'(irq), 0);
    chk("R13 reset dma", int'(dma), 0);
    chk("R13 reset trig", int'(trig), 0);

    // R13 direct counter load
    wr(A_CNT, 42);
    rd(A_CNT, d);
    chk("R13 counter load", d, 42);

    // R1 R8 sweep of prescale and limit
    for (int p = 0; p < 4; p++) begin
      for (int l = 1; l < 6; l++) begin
        setup(p, l);
        wr(A_IEN, 2);
        wr(A_CTRL, 1);
        measure(n);
        chk($sformatf("R8 first overflow p=%0d l=%0d", p, l), n, 1 + (l + 1) * (p + 1));
        measure(n);
        chk($sformatf("R1 period p=%0d l=%0d", p, l), n, (l + 1) * (p + 1));
      end
    end

    // R12 pulse lasts one clock
    @(posedge clk); #1;
    chk("R12 dma one clock", int'(dma), 0);

    // R2 prescale change deferred to update
    setup(0, 3);
    wr(A_PSC, 2);
    wr(A_IEN, 2);
    wr(A_CTRL, 1);
    measure(n);
    chk("R2 old ratio before update", n, 5);
    measure(n);
    chk("R2 new ratio after update", n, 12);

    // R3 limit preload on
    wr(A_CTRL, 16);
    wr(A_PSC, 0);
    wr(A_LIM, 3);
    wr(A_EVT, 1);
    wr(A_STAT, 0);
    wr(A_LIM, 7);
    rd(A_LIM, d);
    chk("R3 limit reads preload", d, 7);
    wr(A_IEN, 2);
    wr(A_CTRL, 17);
    measure(n);
    chk("R3 preload: old limit first", n, 5);
    measure(n);
    chk("R3 preload: new limit after update", n, 8);

    // R3 limit preload off
    setup(0, 3);
    wr(A_LIM, 7);
    wr(A_IEN, 2);
    wr(A_CTRL, 1);
    measure(n);
    chk("R3 direct limit write", n, 9);

    // R4 strobe mid-run
    setup(0, 20);
    wr(A_CTRL, 1);
    repeat (8) @(posedge clk);
    wr(A_EVT, 1);
    rd(A_CNT, d);
    chk("R4 strobe clears counter", d, 0);
    rd(A_STAT, d);
    chk("R4 strobe sets flag", d, 1);
    rd(A_EVT, d);
    chk("R4 event reg reads 0", d, 0);

    // R11 flag and interrupt
    wr(A_CTRL, 0);
    wr(A_IEN, 1);
    chk("R11 irq with enable", int'(irq), 1);
    wr(A_IEN, 0);
    chk("R11 irq masked", int'(irq), 0);
    wr(A_STAT, 1);
    rd(A_STAT, d);
    chk("R11 write 1 no effect", d, 1);
    wr(A_STAT, 0);
    rd(A_STAT, d);
    chk("R11 write 0 clears", d, 0);

    // R12 no request when disabled
    setup(0, 2);
    wr(A_IEN, 1);
    wr(A_CTRL, 1);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (dma) hits++;
    end
    chk("R12 dma disabled", hits, 0);
    chk("R11 overflow raises irq", int'(irq), 1);

    // R6 overflow-only flag source
    setup(0, 2);
    wr(A_CTRL, 4);
    wr(A_EVT, 1);
    rd(A_STAT, d);
    chk("R6 strobe leaves flag", d, 0);
    wr(A_IEN, 2);
    wr(A_CTRL, 5);
    measure(n);
    chk("R6 overflow still flags", n, 4);
    wr(A_CTRL, 0);
    wr(A_STAT, 0);
    wr(A_EVT, 1);
    rd(A_STAT, d);
    chk("R6 strobe flags when bit clear", d, 1);

    // R7 one-shot
    setup(0, 2);
    wr(A_IEN, 2);
    wr(A_CTRL, 9);
    measure(n);
    chk("R7 one-shot overflow", n, 4);
    rd(A_CTRL, d);
    chk("R7 run bit cleared", d, 8);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d);
    chk("R7 counter stays 0", d, 0);

    // R10 zero limit
    setup(0, 0);
    wr(A_CTRL, 1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d);
    chk("R10 counter held", d, 0);
    rd(A_STAT, d);
    chk("R10 no overflow flag", d, 0);

    // R5 update inhibit
    setup(0, 3);
    wr(A_CTRL, 18);
    wr(A_LIM, 9);
    wr(A_EVT, 1);
    rd(A_CNT, d);
    chk("R5 strobe clears under inhibit", d, 0);
    rd(A_STAT, d);
    chk("R5 no flag under inhibit", d, 0);
    wr(A_IEN, 2);
    wr(A_CTRL, 19);
    mx = 0; hits = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rd(A_CNT, d);
      if (d > mx) mx = d;
      if (dma) hits++;
    end
    chk("R5 old limit kept, wraps at 3", mx, 3);
    chk("R5 no request under inhibit", hits, 0);
    rd(A_STAT, d);
    chk("R5 flag stays clear", d, 0);
    wr(A_CTRL, 16);
    wr(A_EVT, 1);
    wr(A_STAT, 0);
    wr(A_CTRL, 17);
    measure(n);
    chk("R5 pending limit applied after inhibit", n, 11);

    // R9 trigger codes, R8 run lag
    wr(A_CTRL, 0);
    wr(A_TRIG, 1);
    chk("R9 run code idle", int'(trig), 0);
    wr(A_CTRL, 1);
    chk("R8 run not yet visible", int'(trig), 0);
    @(posedge clk); #1;
    chk("R8 run visible one clock later", int'(trig), 1);
    wr(A_CTRL, 0);
    wr(A_TRIG, 0);
    wr(A_EVT, 1);
    chk("R9 strobe code pulse", int'(trig), 1);
    @(posedge clk); #1;
    chk("R9 strobe code one clock", int'(trig), 0);
    wr(A_TRIG, 2);
    wr(A_EVT, 1);
    chk("R9 update code pulse", int'(trig), 1);
    wr(A_CTRL, 2);
    wr(A_EVT, 1);
    chk("R9 update code silent under inhibit", int'(trig), 0);
    wr(A_CTRL, 0);
    wr(A_TRIG, 5);
    wr(A_EVT, 1);
    chk("R9 unused code low", int'(trig), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule